// File: doc/BRIEF.md
# PCIe Function Error Signaling Classifier

This block takes one detected error event at a time and decides how a PCIe function records and reports it. An event carries a raw error status vector, a correctable flag, a may-be-advisory flag and a 16-bit requester ID. The block filters the vector against the bits the function supports, picks a severity and applies the mask and enable settings. It then produces, one cycle later, set strobes for the device status bits, set strobes for the correctable and uncorrectable status registers, a request to the header logger and at most one error message.

The status registers themselves sit outside the block; it only produces one-cycle set strobes that a neighbouring register file ORs in. When the header logger answers a log request with an overflow indication, the block handles an internal correctable header-log-overflow error on the next cycle. That error goes through the same gating as any other correctable error. Forwarding the message towards the root is left to other logic.

Top module: `errsig_classifier`

## Requirements
- R1: Before anything else, the raw status is ANDed with the supported set for its class: correctable 0x0000F1C1, uncorrectable 0x077FF030. An event whose filtered vector does not have exactly one bit set is consumed and produces all-zero outputs.
- R2: An uncorrectable error is fatal when its bit is set in `cfg_unc_sev` while `cfg_aer_en` is high. When `cfg_aer_en` is low, only bits 4, 5, 13, 17, 18 and 22 (mask 0x00462030) are fatal, and every other supported uncorrectable bit is nonfatal.
- R3: A correctable error sets `dev_sta_set[0]`, and with `cfg_aer_en` high it also strobes its own bit on `cor_sta_set`. The `dev_sta_set` bits are: 0 correctable, 1 nonfatal, 2 fatal, 3 unsupported request. The unsupported request is uncorrectable bit 20.
- R4: A correctable error whose `cor_sta_set` bit is also set in `cfg_cor_mask` (with `cfg_aer_en` high) has its status strobed but sends no message and requests no log.
- R5: A correctable message requires `cfg_cor_rep_en`. When the error arose from an unsupported request, it also requires `cfg_ur_rep_en`.
- R6: A nonfatal uncorrectable error with `evt_maybe_adv` high is handled as correctable bit 13. Unless bit 13 is masked in `cfg_cor_mask`, its original uncorrectable bit is strobed on `unc_sta_set`, and a log is requested when that bit is clear in `cfg_unc_mask`.
- R7: An uncorrectable, non-advisory error whose bit is set in `cfg_unc_mask` (with `cfg_aer_en` high) sets its device status bit and strobes its uncorrectable status bit. It requests no log and sends no message.
- R8: A fatal message needs `cfg_serr_en` or `cfg_fatal_rep_en`, and a nonfatal message needs `cfg_serr_en` or `cfg_nf_rep_en`. An unsupported request sends nothing when both `cfg_ur_rep_en` and `cfg_serr_en` are low.
- R9: When `log_ovf` is high in a cycle with `log_req` high, the next cycle carries the outputs of a correctable bit-15 error with the same requester ID.
- R10: Outputs appear in the cycle after the `evt_valid`&`evt_ready` handshake. `evt_ready` is low exactly in cycles with `log_req` high. `msg_sev` uses 1 for correctable, 2 for nonfatal and 3 for fatal.
- R11: With `cfg_aer_en` low, no correctable or uncorrectable status strobe and no log request are produced. Masks are ignored, while the device status bits and messages still follow R3, R5 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error event offered |
| evt_ready | output | 1 | Event can be taken this cycle |
| evt_status | input | 32 | Raw error status vector |
| evt_is_cor | input | 1 | Event is of the correctable class |
| evt_maybe_adv | input | 1 | Event may be treated as advisory |
| evt_src | input | 16 | Requester ID of the event |
| cfg_aer_en | input | 1 | Advanced reporting registers present |
| cfg_unc_mask | input | 32 | Uncorrectable mask |
| cfg_unc_sev | input | 32 | Uncorrectable severity (1 = fatal) |
| cfg_cor_mask | input | 32 | Correctable mask |
| cfg_cor_rep_en | input | 1 | Correctable reporting enable |
| cfg_nf_rep_en | input | 1 | Nonfatal reporting enable |
| cfg_fatal_rep_en | input | 1 | Fatal reporting enable |
| cfg_ur_rep_en | input | 1 | Unsupported-request reporting enable |
| cfg_serr_en | input | 1 | System-error enable from command register |
| log_ovf | input | 1 | Header logger could not store the request |
| dev_sta_set | output | 4 | Device status set strobes |
| cor_sta_set | output | 32 | Correctable status set strobes |
| unc_sta_set | output | 32 | Uncorrectable status set strobes |
| log_req | output | 1 | Header log request |
| log_status | output | 32 | One-hot uncorrectable bit to log |
| msg_valid | output | 1 | Error message pulse |
| msg_sev | output | 2 | Message severity code |
| msg_src | output | 16 | Message requester ID |

## Verification
The only state carried from one cycle to the next is the registered output set plus the saved requester ID. A fault in the severity, mask or gating logic therefore shows up in the single output cycle that follows the handshake, and the bench compares every output field on every clock. If the overflow follow-up is wrong, the error appears in the second cycle after acceptance: a missing strobe, a wrong ID, or `evt_ready` left low. A wrong ready term shows directly at the port in the same cycle as the log request.

// File: rtl/errsig_pkg.sv
package errsig_pkg;
    parameter int unsigned STAT_W = 32;
    parameter int unsigned SRC_W  = 16;
    parameter int unsigned DSTA_W = 4;

    localparam logic [STAT_W-1:0] COR_SUPPORTED = STAT_W'(32'h0000F1C1);
    localparam logic [STAT_W-1:0] UNC_SUPPORTED = STAT_W'(32'h077FF030);
    localparam logic [STAT_W-1:0] UNC_FATAL_DEF = STAT_W'(32'h00462030);

    localparam int unsigned UR_BIT  = 20;
    localparam int unsigned ADV_BIT = 13;
    localparam int unsigned HLO_BIT = 15;

    localparam int unsigned DS_COR = 0;
    localparam int unsigned DS_NF  = 1;
    localparam int unsigned DS_FAT = 2;
    localparam int unsigned DS_UR  = 3;

    typedef enum logic [1:0] {
        SEV_NONE     = 2'd0,
        SEV_COR      = 2'd1,
        SEV_NONFATAL = 2'd2,
        SEV_FATAL    = 2'd3
    } sev_e;

    typedef struct packed {
        logic [DSTA_W-1:0] dsta;
        logic [STAT_W-1:0] cor;
        logic [STAT_W-1:0] unc;
        logic              log_req;
        logic [STAT_W-1:0] log_st;
        logic              msg_v;
        sev_e              sev;
        logic [SRC_W-1:0]  src;
    } sig_t;

    typedef struct packed {
        sig_t             out;
        logic [SRC_W-1:0] src_hold;
    } state_t;
endpackage

// File: rtl/errsig_decode.sv
module errsig_decode
    import errsig_pkg::*;
(
    input  logic [STAT_W-1:0] raw,
    input  logic              is_cor,
    input  logic              aer_en,
    input  logic [STAT_W-1:0] sev_prog,
    output logic [STAT_W-1:0] sup,
    output logic              ok,
    output logic              is_ur,
    output logic              is_fatal
);
    logic [STAT_W-1:0] fatal_set;

    always_comb begin
        sup       = raw & (is_cor ? COR_SUPPORTED : UNC_SUPPORTED);
        ok        = (sup != '0) && ((sup & (sup - STAT_W'(1))) == '0);
        is_ur     = !is_cor && (sup == (STAT_W'(1) << UR_BIT));
        fatal_set = aer_en ? sev_prog : UNC_FATAL_DEF;
        is_fatal  = !is_cor && ((sup & fatal_set) != '0);
    end
endmodule

// File: rtl/errsig_route.sv
module errsig_route
    import errsig_pkg::*;
(
    input  logic              ok,
    input  logic              is_cor,
    input  logic              adv,
    input  logic              is_ur,
    input  logic              is_fatal,
    input  logic [STAT_W-1:0] sup,
    input  logic [SRC_W-1:0]  src,
    input  logic              aer_en,
    input  logic [STAT_W-1:0] unc_mask,
    input  logic [STAT_W-1:0] cor_mask,
    input  logic              cor_rep_en,
    input  logic              nf_rep_en,
    input  logic              fatal_rep_en,
    input  logic              ur_rep_en,
    input  logic              serr_en,
    output sig_t              res
);
    logic [STAT_W-1:0] cstat;
    logic              stop;
    logic              send;

    always_comb begin
        res   = '0;
        cstat = '0;
        stop  = 1'b0;
        send  = 1'b0;
        if (ok) begin
            if (is_cor || (!is_fatal && adv)) begin
                cstat              = is_cor ? sup : (STAT_W'(1) << ADV_BIT);
                res.dsta[DS_COR]   = 1'b1;
                res.dsta[DS_UR]    = is_ur;
                if (aer_en) begin
                    res.cor = cstat;
                    if ((cstat & cor_mask) != '0) begin
                        stop = 1'b1;
                    end else if (!is_cor) begin
                        res.unc = sup;
                        if ((sup & unc_mask) == '0) begin
                            res.log_req = 1'b1;
                            res.log_st  = sup;
                        end
                    end
                end
                send = !stop && cor_rep_en && !(is_ur && !ur_rep_en);
                if (send) begin
                    res.sev = SEV_COR;
                end
            end else begin
                res.dsta[DS_FAT] = is_fatal;
                res.dsta[DS_NF]  = !is_fatal;
                res.dsta[DS_UR]  = is_ur;
                if (aer_en) begin
                    res.unc = sup;
                    if ((sup & unc_mask) != '0) begin
                        stop = 1'b1;
                    end else begin
                        res.log_req = 1'b1;
                        res.log_st  = sup;
                    end
                end
                if (!stop && !(is_ur && !ur_rep_en && !serr_en)) begin
                    send = serr_en || (is_fatal ? fatal_rep_en : nf_rep_en);
                end
                if (send) begin
                    res.sev = is_fatal ? SEV_FATAL : SEV_NONFATAL;
                end
            end
            res.msg_v = send;
            res.src   = send ? src : '0;
        end
    end
endmodule

// File: rtl/errsig_classifier.sv
module errsig_classifier
    import errsig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [31:0]       evt_status,
    input  logic              evt_is_cor,
    input  logic              evt_maybe_adv,
    input  logic [15:0]       evt_src,
    input  logic              cfg_aer_en,
    input  logic [31:0]       cfg_unc_mask,
    input  logic [31:0]       cfg_unc_sev,
    input  logic [31:0]       cfg_cor_mask,
    input  logic              cfg_cor_rep_en,
    input  logic              cfg_nf_rep_en,
    input  logic              cfg_fatal_rep_en,
    input  logic              cfg_ur_rep_en,
    input  logic              cfg_serr_en,
    input  logic              log_ovf,
    output logic [3:0]        dev_sta_set,
    output logic [31:0]       cor_sta_set,
    output logic [31:0]       unc_sta_set,
    output logic              log_req,
    output logic [31:0]       log_status,
    output logic              msg_valid,
    output logic [1:0]        msg_sev,
    output logic [15:0]       msg_src
);
    state_t            st_d, st_q;
    logic              accept, ovf_go;
    logic [STAT_W-1:0] raw_sel;
    logic              cor_sel, adv_sel;
    logic [SRC_W-1:0]  src_sel;
    logic [STAT_W-1:0] dec_sup;
    logic              dec_ok, dec_ur, dec_fatal;
    sig_t              route_res;

    assign evt_ready = !st_q.out.log_req;
    assign accept    = evt_valid && evt_ready;
    assign ovf_go    = st_q.out.log_req && log_ovf;

    always_comb begin
        raw_sel = ovf_go ? (STAT_W'(1) << HLO_BIT) : evt_status;
        cor_sel = ovf_go || evt_is_cor;
        adv_sel = !ovf_go && evt_maybe_adv;
        src_sel = ovf_go ? st_q.src_hold : evt_src;
    end

    errsig_decode u_decode (
        .raw      (raw_sel),
        .is_cor   (cor_sel),
        .aer_en   (cfg_aer_en),
        .sev_prog (cfg_unc_sev),
        .sup      (dec_sup),
        .ok       (dec_ok),
        .is_ur    (dec_ur),
        .is_fatal (dec_fatal)
    );

    errsig_route u_route (
        .ok           (dec_ok),
        .is_cor       (cor_sel),
        .adv          (adv_sel),
        .is_ur        (dec_ur),
        .is_fatal     (dec_fatal),
        .sup          (dec_sup),
        .src          (src_sel),
        .aer_en       (cfg_aer_en),
        .unc_mask     (cfg_unc_mask),
        .cor_mask     (cfg_cor_mask),
        .cor_rep_en   (cfg_cor_rep_en),
        .nf_rep_en    (cfg_nf_rep_en),
        .fatal_rep_en (cfg_fatal_rep_en),
        .ur_rep_en    (cfg_ur_rep_en),
        .serr_en      (cfg_serr_en),
        .res          (route_res)
    );

    always_comb begin
        st_d          = st_q;
        st_d.out      = (accept || ovf_go) ? route_res : '0;
        st_d.src_hold = accept ? evt_src : st_q.src_hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dev_sta_set = st_q.out.dsta;
    assign cor_sta_set = st_q.out.cor;
    assign unc_sta_set = st_q.out.unc;
    assign log_req     = st_q.out.log_req;
    assign log_status  = st_q.out.log_st;
    assign msg_valid   = st_q.out.msg_v;
    assign msg_sev     = st_q.out.sev;
    assign msg_src     = st_q.out.src;
endmodule

// File: rtl/errsig_checker.sv
module errsig_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        evt_valid,
    input logic        evt_ready,
    input logic        log_ovf,
    input logic [3:0]  dev_sta_set,
    input logic [31:0] cor_sta_set,
    input logic [31:0] unc_sta_set,
    input logic        log_req,
    input logic [31:0] log_status,
    input logic        msg_valid,
    input logic [1:0]  msg_sev
);
    a_r10_ready_low_on_log: assert property (@(posedge clk) disable iff (!rst_n)
        log_req |-> !evt_ready);

    a_r9_overflow_followup: assert property (@(posedge clk) disable iff (!rst_n)
        (log_req && log_ovf) |=> dev_sta_set[0]);

    a_r6_log_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        log_req |-> ($countones(log_status) == 1));

    a_r3_cor_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cor_sta_set));

    a_r7_unc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unc_sta_set));

    a_r10_msg_sev_coded: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_sev != 2'd0));

    a_r10_quiet_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!(evt_valid && evt_ready) && !(log_req && log_ovf))
        |=> (!msg_valid && dev_sta_set == 4'd0 && !log_req));
endmodule

bind errsig_classifier errsig_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .evt_ready   (evt_ready),
    .log_ovf     (log_ovf),
    .dev_sta_set (dev_sta_set),
    .cor_sta_set (cor_sta_set),
    .unc_sta_set (unc_sta_set),
    .log_req     (log_req),
    .log_status  (log_status),
    .msg_valid   (msg_valid),
    .msg_sev     (msg_sev)
);

// File: tb/errsig_classifier_tb.sv
module errsig_classifier_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [31:0] evt_status = '0;
    logic        evt_is_cor = 1'b0;
    logic        evt_maybe_adv = 1'b0;
    logic [15:0] evt_src = '0;
    logic        cfg_aer_en = 1'b1;
    logic [31:0] cfg_unc_mask = '0;
    logic [31:0] cfg_unc_sev = 32'h00462030;
    logic [31:0] cfg_cor_mask = '0;
    logic        cfg_cor_rep_en = 1'b1;
    logic        cfg_nf_rep_en = 1'b1;
    logic        cfg_fatal_rep_en = 1'b1;
    logic        cfg_ur_rep_en = 1'b1;
    logic        cfg_serr_en = 1'b0;
    logic        log_ovf = 1'b0;
    logic [3:0]  dev_sta_set;
    logic [31:0] cor_sta_set, unc_sta_set, log_status;
    logic        log_req, msg_valid;
    logic [1:0]  msg_sev;
    logic [15:0] msg_src;

    always #5 clk = ~clk;

    errsig_classifier u_dut (.*);

    typedef struct {
        logic [3:0]  dsta;
        logic [31:0] cor;
        logic [31:0] unc;
        logic        lreq;
        logic [31:0] lst;
        logic        mv;
        logic [1:0]  sev;
        logic [15:0] src;
    } exp_t;

    exp_t        ex;
    logic [15:0] m_src_hold = '0;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          cyc = 0;
    bit          done = 0;
    string       cur_req = "R10 reset";

    function automatic exp_t predict(input logic [31:0] raw, input bit isc,
                                     input bit adv, input logic [15:0] src);
        exp_t        e;
        logic [31:0] sup, cst;
        bit          ur, fat, blocked, tx;
        e = '{default: '0};
        sup = raw & (isc ? 32'h0000F1C1 : 32'h077FF030);
        if ($countones(sup) != 1) return e;
        ur  = !isc && (sup == 32'h00100000);
        fat = !isc && ((cfg_aer_en ? (sup & cfg_unc_sev) : (sup & 32'h00462030)) != 0);
        blocked = 0;
        tx = 0;
        if (isc || (!fat && adv)) begin
            cst = isc ? sup : 32'h00002000;
            e.dsta = {ur, 3'b001};
            if (cfg_aer_en) begin
                e.cor = cst;
                if ((cst & cfg_cor_mask) != 0) blocked = 1;
                else if (!isc) begin
                    e.unc = sup;
                    if ((sup & cfg_unc_mask) == 0) begin e.lreq = 1; e.lst = sup; end
                end
            end
            tx = !blocked && cfg_cor_rep_en && (!ur || cfg_ur_rep_en);
            e.sev = tx ? 2'd1 : 2'd0;
        end else begin
            e.dsta = {ur, fat, !fat, 1'b0};
            if (cfg_aer_en) begin
                e.unc = sup;
                if ((sup & cfg_unc_mask) != 0) blocked = 1;
                else begin e.lreq = 1; e.lst = sup; end
            end
            if (!blocked && !(ur && !cfg_ur_rep_en && !cfg_serr_en))
                tx = cfg_serr_en || (fat ? cfg_fatal_rep_en : cfg_nf_rep_en);
            e.sev = tx ? (fat ? 2'd3 : 2'd2) : 2'd0;
        end
        e.mv  = tx;
        e.src = tx ? src : 16'h0;
        return e;
    endfunction

    always @(posedge clk) begin
        exp_t nx;
        cyc <= cyc + 1;
        nx = '{default: '0};
        if (!rst_n) begin
            m_src_hold <= '0;
        end else if (evt_valid && !ex.lreq) begin
            nx = predict(evt_status, evt_is_cor, evt_maybe_adv, evt_src);
            m_src_hold <= evt_src;
        end else if (ex.lreq && log_ovf) begin
            nx = predict(32'h00008000, 1'b1, 1'b0, m_src_hold);
        end
        ex <= nx;
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exv);
        n_cmp++;
        if (act !== exv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exv);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("evt_ready", 32'(evt_ready), 32'(!ex.lreq));
            chk("dev_sta_set", 32'(dev_sta_set), 32'(ex.dsta));
            chk("cor_sta_set", cor_sta_set, ex.cor);
            chk("unc_sta_set", unc_sta_set, ex.unc);
            chk("log_req", 32'(log_req), 32'(ex.lreq));
            chk("log_status", log_status, ex.lst);
            chk("msg_valid", 32'(msg_valid), 32'(ex.mv));
            chk("msg_sev", 32'(msg_sev), 32'(ex.sev));
            chk("msg_src", 32'(msg_src), 32'(ex.src));
        end
    end

    task automatic send(string tag, logic [31:0] raw, bit isc, bit adv,
                        logic [15:0] src, bit ovf, int hold);
        cur_req       = tag;
        evt_status    = raw;
        evt_is_cor    = isc;
        evt_maybe_adv = adv;
        evt_src       = src;
        log_ovf       = ovf;
        evt_valid     = 1'b1;
        repeat (hold) @(negedge clk);
        evt_valid = 1'b0;
        repeat (4) @(negedge clk);
        log_ovf = 1'b0;
    endtask

    initial begin
        ex = '{default: '0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: filtering and one-hot rule
        send("R1 unsupported-only", 32'h00000003, 0, 0, 16'h0101, 0, 1);
        send("R1 two bits", 32'h00000030, 0, 0, 16'h0102, 0, 1);
        send("R1 cor multi", 32'h000001C1, 1, 0, 16'h0103, 0, 1);
        send("R1 filtered to one", 32'h00004001, 0, 0, 16'h0104, 0, 1);
        // R3: correctable status
        send("R3 cor bit6", 32'h00000040, 1, 0, 16'h0201, 0, 1);
        // R4: correctable mask
        cfg_cor_mask = 32'h00000040;
        send("R4 cor masked", 32'h00000040, 1, 0, 16'h0301, 0, 1);
        cfg_cor_mask = '0;
        // R5: correctable reporting enable
        cfg_cor_rep_en = 0;
        send("R5 cor disabled", 32'h00000001, 1, 0, 16'h0401, 0, 1);
        cfg_cor_rep_en = 1;
        send("R5 cor enabled", 32'h00001000, 1, 0, 16'h0402, 0, 1);
        // R2: severity selection
        cfg_aer_en = 0;
        send("R2 default fatal", 32'h00000010, 0, 0, 16'h0501, 0, 1);
        send("R2 default nonfatal", 32'h00004000, 0, 0, 16'h0502, 0, 1);
        cfg_aer_en = 1;
        cfg_unc_sev = 32'h00004000;
        send("R2 programmed fatal", 32'h00004000, 0, 0, 16'h0503, 0, 1);
        send("R2 programmed nonfatal", 32'h00000010, 0, 0, 16'h0504, 0, 1);
        cfg_unc_sev = 32'h00462030;
        // R6: advisory nonfatal
        send("R6 advisory logged", 32'h00004000, 0, 1, 16'h0601, 0, 1);
        cfg_unc_mask = 32'h00004000;
        send("R6 advisory unc masked", 32'h00004000, 0, 1, 16'h0602, 0, 1);
        cfg_unc_mask = '0;
        cfg_cor_mask = 32'h00002000;
        send("R6 advisory cor masked", 32'h00004000, 0, 1, 16'h0603, 0, 1);
        cfg_cor_mask = '0;
        send("R6 advisory on fatal ignored", 32'h00000020, 0, 1, 16'h0604, 0, 1);
        cfg_ur_rep_en = 0;
        send("R5 advisory UR gated", 32'h00100000, 0, 1, 16'h0605, 0, 1);
        cfg_ur_rep_en = 1;
        // R7: masked uncorrectable
        cfg_unc_mask = 32'h00001000;
        send("R7 unc masked", 32'h00001000, 0, 0, 16'h0701, 0, 1);
        cfg_unc_mask = '0;
        // R8: message gating
        cfg_nf_rep_en = 0; cfg_fatal_rep_en = 0; cfg_serr_en = 1;
        send("R8 fatal via serr", 32'h00000020, 0, 0, 16'h0801, 0, 1);
        cfg_serr_en = 0;
        send("R8 fatal blocked", 32'h00000020, 0, 0, 16'h0802, 0, 1);
        send("R8 nonfatal blocked", 32'h00004000, 0, 0, 16'h0803, 0, 1);
        cfg_nf_rep_en = 1;
        send("R8 nonfatal enabled", 32'h00004000, 0, 0, 16'h0804, 0, 1);
        cfg_ur_rep_en = 0;
        send("R8 UR suppressed", 32'h00100000, 0, 0, 16'h0805, 0, 1);
        cfg_serr_en = 1; cfg_nf_rep_en = 0;
        send("R8 UR via serr", 32'h00100000, 0, 0, 16'h0806, 0, 1);
        cfg_serr_en = 0; cfg_nf_rep_en = 1; cfg_ur_rep_en = 1;
        send("R8 UR reported", 32'h00100000, 0, 0, 16'h0807, 0, 1);
        // R9: header log overflow follow-up
        send("R9 overflow", 32'h00004000, 0, 0, 16'h0901, 1, 1);
        cfg_cor_mask = 32'h00008000;
        send("R9 overflow masked", 32'h00000020, 0, 0, 16'h0902, 1, 1);
        cfg_cor_mask = '0;
        send("R9 advisory overflow", 32'h00004000, 0, 1, 16'h0903, 1, 1);
        // R10: handshake under held valid
        send("R10 cor burst", 32'h00000080, 1, 0, 16'h0A01, 0, 5);
        send("R10 log burst", 32'h00010000, 0, 0, 16'h0A02, 0, 5);
        send("R10 log burst ovf", 32'h00008000, 0, 0, 16'h0A03, 1, 5);
        // R11: capability absent
        cfg_aer_en = 0;
        cfg_cor_mask = 32'hFFFFFFFF;
        cfg_unc_mask = 32'hFFFFFFFF;
        send("R11 cor no aer", 32'h00000100, 1, 0, 16'h0B01, 0, 1);
        send("R11 unc no aer", 32'h00000010, 0, 0, 16'h0B02, 1, 1);
        send("R11 adv no aer", 32'h00004000, 0, 1, 16'h0B03, 0, 1);
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule